// File: doc/BRIEF.md
# UART Byte FIFO Controller with Threshold Interrupts

This block manages the receive and transmit byte queues of one UART channel. It keeps a write pointer, a read pointer and a fill level for each 64-entry queue and hands the pointers out as addresses for an external byte store. Push and pop strobes arrive from the serial side (receive push, transmit pop) and from the host side (receive pop, transmit push). The block does not hold the bytes themselves, nor the shift registers, baud timing or any other register.

An 8-bit control word written by the host enables the queues and can flush either queue. It also selects a mode flag for block transfers and picks one trigger code that both directions share. From the levels and the trigger points the block raises a receive interrupt and a transmit interrupt. The receive interrupt follows a simple two-state machine: RX_UNDER (level below trigger, no request) and RX_OVER (level at or above trigger, request). The transmit interrupt uses three states. TX_REQ is the request state. TX_FILLED means the host refilled the queue to the trigger or beyond. TX_HELD means the queue sits below a trigger that was raised under it, and no request is made. The named transitions are: fill (REQ to FILLED when the next level is non-zero and at or above trigger), drain (FILLED to REQ when a pop takes the level below trigger, or the level reaches 0), raise (FILLED to HELD when the level is below the trigger without a pop), empty (HELD to REQ at level 0) and refill (HELD to FILLED at or above trigger).

The control word is laid out as follows. Bit 0 is the queue enable. Bit 1 flushes the receive queue and bit 2 flushes the transmit queue. Bit 3 is the block-transfer mode. Bits 5:4 are the transmit trigger field and bits 7:6 are the receive trigger field.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset, cfg_rdata is 0x00, both levels and all four pointers are 0, both interrupts and all four error flags are low, rx_trig is 8 and tx_trig is 1.
- R2: While cfg_rdata bit 0 (enable) is 0, push and pop strobes are ignored. Both levels are forced to 0 one clock after enable reads 0, no error flag is raised, and both interrupts are low.
- R3: When enabled, a push adds 1 to the level if the level is below 64, and a pop subtracts 1 if the level is above 0. A push and a pop in the same cycle are both applied when each is allowed. Each accepted push advances the write pointer and each accepted pop advances the read pointer, modulo 64.
- R4: A push at level 64 sets the overrun flag for the next cycle only. A pop at level 0 sets the underrun flag for the next cycle only. The rejected strobe leaves the level and pointers unchanged.
- R5: A write with bits 0 and 1 both set makes cfg_rdata bit 1 read 1 for one cycle. At the following edge the receive level and both receive pointers become 0, and the bit reads 0 again. Bit 2 does the same for the transmit queue. With bit 0 clear in the write, bits 1 and 2 read back 0.
- R6: Bit 3 of a control write is held as the block-transfer mode and appears on dma_mode and cfg_rdata bit 3.
- R7: Each control write sets one shared trigger code. The code is taken from bits 5:4 when enh_en is 1, and from bits 7:6 otherwise. rx_trig decodes the code 0,1,2,3 to 8,16,56,60.
- R8: When enh_en was 1 at the previous edge, tx_trig decodes the shared code 0,1,2,3 to 8,16,32,56. Otherwise tx_trig is 1.
- R9: cfg_rdata bits 7:6 always hold the last written bits 7:6. Bits 5:4 update only on writes made while enh_en is 1.
- R10: When enabled, rx_irq is 1 exactly when rx_level is at or above rx_trig.
- R11: When enabled, tx_irq rises when a pop takes tx_level from at or above tx_trig to below it. Once high, it stays high until tx_level is non-zero and at or above tx_trig.
- R12: When enabled, tx_irq is 1 whenever tx_level is 0.
- R13: If tx_level falls below tx_trig because the trigger was raised, with no pop, tx_irq stays low through later pops until tx_level reaches 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 8 | Control word write data |
| enh_en | input | 1 | Enhanced-mode enable; gates the transmit trigger field |
| rx_push | input | 1 | Receive byte arrives from the serial side |
| rx_pop | input | 1 | Host reads a receive byte |
| tx_push | input | 1 | Host writes a transmit byte |
| tx_pop | input | 1 | Serial side takes a transmit byte |
| cfg_rdata | output | 8 | Control word readback |
| dma_mode | output | 1 | Block-transfer mode flag |
| rx_wr_addr | output | 6 | Receive store write address |
| rx_rd_addr | output | 6 | Receive store read address |
| tx_wr_addr | output | 6 | Transmit store write address |
| tx_rd_addr | output | 6 | Transmit store read address |
| rx_level | output | 7 | Receive fill level, 0 to 64 |
| tx_level | output | 7 | Transmit fill level, 0 to 64 |
| rx_trig | output | 7 | Active receive trigger point |
| tx_trig | output | 7 | Active transmit trigger point |
| rx_irq | output | 1 | Receive threshold interrupt |
| tx_irq | output | 1 | Transmit threshold interrupt |
| rx_overrun | output | 1 | Push rejected on a full receive queue |
| rx_underrun | output | 1 | Pop rejected on an empty receive queue |
| tx_overrun | output | 1 | Push rejected on a full transmit queue |
| tx_underrun | output | 1 | Pop rejected on an empty transmit queue |

## Verification
The properties assume that the queue depth is a power of two, so pointer subtraction wraps to the level. They also assume that strobes and control writes are ordinary single-cycle levels sampled at the rising edge, with no meaning given to a strobe held across several edges. The stimulus changes every input only at the falling edge. It holds each strobe for exactly one edge, and it always follows a flush write with an idle cycle before the next write, so every pending flush completes before another control write arrives. The sweep covers every trigger code with enh_en both low and high. It fills and drains both queues through full and empty, including simultaneous push and pop at the boundaries.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    typedef enum logic [0:0] {
        RX_UNDER,
        RX_OVER
    } rx_irq_st_t;

    typedef enum logic [1:0] {
        TX_REQ,
        TX_FILLED,
        TX_HELD
    } tx_irq_st_t;

    // Receive trigger decode of the shared code
    function automatic int unsigned rx_level_of(input logic [1:0] code);
        unique case (code)
            2'd0:    return 8;
            2'd1:    return 16;
            2'd2:    return 56;
            default: return 60;
        endcase
    endfunction

    // Transmit trigger decode of the shared code (enhanced mode only)
    function automatic int unsigned tx_level_of(input logic [1:0] code);
        unique case (code)
            2'd0:    return 8;
            2'd1:    return 16;
            2'd2:    return 32;
            default: return 56;
        endcase
    endfunction

endpackage

// File: rtl/uart_fifo_cfg.sv
module uart_fifo_cfg
    import uart_fifo_pkg::*;
#(
    parameter int LW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [7:0]    cfg_wdata,
    input  logic          enh_en,
    output logic          fifo_en,
    output logic          dma_mode,
    output logic          rx_flush_pend,
    output logic          tx_flush_pend,
    output logic [7:0]    cfg_rdata,
    output logic [LW-1:0] rx_trig,
    output logic [LW-1:0] tx_trig,
    output logic [LW-1:0] rx_trig_nxt,
    output logic [LW-1:0] tx_trig_nxt
);

    logic [1:0] code_q, code_nxt;
    logic [1:0] rx_fld_q, tx_fld_q;
    logic       enh_q;

    // R7: the shared code comes from the field that is writable last
    always_comb begin
        code_nxt = code_q;
        if (cfg_wr) begin
            code_nxt = enh_en ? cfg_wdata[5:4] : cfg_wdata[7:6];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q        <= '0;
            rx_fld_q      <= '0;
            tx_fld_q      <= '0;
            enh_q         <= 1'b0;
            fifo_en       <= 1'b0;
            dma_mode      <= 1'b0;
            rx_flush_pend <= 1'b0;
            tx_flush_pend <= 1'b0;
        end else begin
            code_q        <= code_nxt;
            enh_q         <= enh_en;
            // R5: flush requests are single-cycle and need the enable bit
            rx_flush_pend <= cfg_wr & cfg_wdata[0] & cfg_wdata[1];
            tx_flush_pend <= cfg_wr & cfg_wdata[0] & cfg_wdata[2];
            if (cfg_wr) begin
                fifo_en  <= cfg_wdata[0];
                dma_mode <= cfg_wdata[3];
                rx_fld_q <= cfg_wdata[7:6];
                if (enh_en) begin
                    tx_fld_q <= cfg_wdata[5:4];
                end
            end
        end
    end

    always_comb begin
        rx_trig     = LW'(rx_level_of(code_q));
        tx_trig     = enh_q ? LW'(tx_level_of(code_q)) : LW'(1);
        rx_trig_nxt = LW'(rx_level_of(code_nxt));
        tx_trig_nxt = enh_en ? LW'(tx_level_of(code_nxt)) : LW'(1);
        cfg_rdata   = {rx_fld_q, tx_fld_q, dma_mode, tx_flush_pend,
                       rx_flush_pend, fifo_en};
    end

endmodule

// File: rtl/uart_fifo_lane.sv
module uart_fifo_lane #(
    parameter int DEPTH = 64,
    parameter int AW    = 6,
    parameter int LW    = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [LW-1:0] level,
    output logic [LW-1:0] level_nxt,
    output logic          pop_acc,
    output logic          overrun,
    output logic          underrun
);

    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

    logic full, empty, push_ok, pop_ok;

    always_comb begin
        full    = (level == FULL_LVL);
        empty   = (level == '0);
        push_ok = active & ~flush & push & ~full;
        pop_ok  = active & ~flush & pop & ~empty;
        pop_acc = pop_ok;
        level_nxt = level;
        if (flush) begin
            level_nxt = '0;
        end else begin
            unique case ({push_ok, pop_ok})
                2'b10:   level_nxt = level + LW'(1);
                2'b01:   level_nxt = level - LW'(1);
                default: level_nxt = level;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            level    <= '0;
            overrun  <= 1'b0;
            underrun <= 1'b0;
        end else begin
            level    <= level_nxt;
            overrun  <= active & ~flush & push & full;
            underrun <= active & ~flush & pop & empty;
            if (flush) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
            end else begin
                if (push_ok) wr_ptr <= wr_ptr + AW'(1);
                if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
            end
        end
    end

endmodule

// File: rtl/uart_rx_irq_fsm.sv
module uart_rx_irq_fsm
    import uart_fifo_pkg::*;
#(
    parameter int LW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [LW-1:0] level_nxt,
    input  logic [LW-1:0] trig_nxt,
    output logic          irq
);

    rx_irq_st_t st_q, st_nxt;

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            RX_UNDER: if (level_nxt >= trig_nxt) st_nxt = RX_OVER;
            RX_OVER:  if (level_nxt <  trig_nxt) st_nxt = RX_UNDER;
            default:  st_nxt = RX_UNDER;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RX_UNDER;
        else        st_q <= st_nxt;
    end

    always_comb begin
        irq = enable && (st_q == RX_OVER);
    end

endmodule

// File: rtl/uart_tx_irq_fsm.sv
module uart_tx_irq_fsm
    import uart_fifo_pkg::*;
#(
    parameter int LW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [LW-1:0] level_nxt,
    input  logic [LW-1:0] trig_nxt,
    input  logic          pop_acc,
    output logic          irq
);

    tx_irq_st_t st_q, st_nxt;

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            TX_REQ: begin
                // fill
                if (level_nxt != '0 && level_nxt >= trig_nxt) st_nxt = TX_FILLED;
            end
            TX_FILLED: begin
                if (level_nxt == '0)            st_nxt = TX_REQ;    // drain
                else if (level_nxt < trig_nxt)  st_nxt = pop_acc ? TX_REQ   // drain
                                                                 : TX_HELD; // raise
            end
            TX_HELD: begin
                if (level_nxt == '0)            st_nxt = TX_REQ;    // empty
                else if (level_nxt >= trig_nxt) st_nxt = TX_FILLED; // refill
            end
            default: st_nxt = TX_REQ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TX_REQ;
        else        st_q <= st_nxt;
    end

    always_comb begin
        irq = enable && (st_q == TX_REQ);
    end

endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH),
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [7:0]    cfg_wdata,
    input  logic          enh_en,
    input  logic          rx_push,
    input  logic          rx_pop,
    input  logic          tx_push,
    input  logic          tx_pop,
    output logic [7:0]    cfg_rdata,
    output logic          dma_mode,
    output logic [AW-1:0] rx_wr_addr,
    output logic [AW-1:0] rx_rd_addr,
    output logic [AW-1:0] tx_wr_addr,
    output logic [AW-1:0] tx_rd_addr,
    output logic [LW-1:0] rx_level,
    output logic [LW-1:0] tx_level,
    output logic [LW-1:0] rx_trig,
    output logic [LW-1:0] tx_trig,
    output logic          rx_irq,
    output logic          tx_irq,
    output logic          rx_overrun,
    output logic          rx_underrun,
    output logic          tx_overrun,
    output logic          tx_underrun
);

    logic          fifo_en, rx_pend, tx_pend;
    logic [LW-1:0] rx_trig_nxt, tx_trig_nxt;
    logic [LW-1:0] rx_lvl_nxt, tx_lvl_nxt;
    logic          rx_pop_acc, tx_pop_acc;
    logic          rx_flush, tx_flush;

    uart_fifo_cfg #(.LW(LW)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr       (cfg_wr),
        .cfg_wdata    (cfg_wdata),
        .enh_en       (enh_en),
        .fifo_en      (fifo_en),
        .dma_mode     (dma_mode),
        .rx_flush_pend(rx_pend),
        .tx_flush_pend(tx_pend),
        .cfg_rdata    (cfg_rdata),
        .rx_trig      (rx_trig),
        .tx_trig      (tx_trig),
        .rx_trig_nxt  (rx_trig_nxt),
        .tx_trig_nxt  (tx_trig_nxt)
    );

    always_comb begin
        rx_flush = rx_pend | ~fifo_en;
        tx_flush = tx_pend | ~fifo_en;
    end

    uart_fifo_lane #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) u_rx_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (fifo_en),
        .flush    (rx_flush),
        .push     (rx_push),
        .pop      (rx_pop),
        .wr_ptr   (rx_wr_addr),
        .rd_ptr   (rx_rd_addr),
        .level    (rx_level),
        .level_nxt(rx_lvl_nxt),
        .pop_acc  (rx_pop_acc),
        .overrun  (rx_overrun),
        .underrun (rx_underrun)
    );

    uart_fifo_lane #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) u_tx_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (fifo_en),
        .flush    (tx_flush),
        .push     (tx_push),
        .pop      (tx_pop),
        .wr_ptr   (tx_wr_addr),
        .rd_ptr   (tx_rd_addr),
        .level    (tx_level),
        .level_nxt(tx_lvl_nxt),
        .pop_acc  (tx_pop_acc),
        .overrun  (tx_overrun),
        .underrun (tx_underrun)
    );

    uart_rx_irq_fsm #(.LW(LW)) u_rx_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (fifo_en),
        .level_nxt(rx_lvl_nxt),
        .trig_nxt (rx_trig_nxt),
        .irq      (rx_irq)
    );

    uart_tx_irq_fsm #(.LW(LW)) u_tx_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (fifo_en),
        .level_nxt(tx_lvl_nxt),
        .trig_nxt (tx_trig_nxt),
        .pop_acc  (tx_pop_acc),
        .irq      (tx_irq)
    );

endmodule

// File: rtl/uart_fifo_ctrl_chk.sv
module uart_fifo_ctrl_chk #(
    parameter int DEPTH = 64,
    parameter int AW    = 6,
    parameter int LW    = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic [7:0]    cfg_rdata,
    input logic [AW-1:0] rx_wr_addr,
    input logic [AW-1:0] rx_rd_addr,
    input logic [LW-1:0] rx_level,
    input logic [LW-1:0] tx_level,
    input logic [LW-1:0] rx_trig,
    input logic          rx_irq,
    input logic          tx_irq,
    input logic          rx_overrun,
    input logic          tx_underrun
);

    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

    p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_level <= FULL_LVL && tx_level <= FULL_LVL);

    p_ptr_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        AW'(rx_wr_addr - rx_rd_addr) == rx_level[AW-1:0]);

    p_overrun_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |-> $past(rx_level) == FULL_LVL);

    p_underrun_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_underrun |-> $past(tx_level) == '0);

    p_flush_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[1] |=> rx_level == '0);

    p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rdata[0] |-> !rx_irq && !tx_irq);

    p_disabled_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rdata[0] |=> rx_level == '0 && tx_level == '0);

    p_rx_irq_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[0] |-> rx_irq == (rx_level >= rx_trig));

    p_tx_empty_irq_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[0] && tx_level == '0 |-> tx_irq);

endmodule

bind uart_fifo_ctrl uart_fifo_ctrl_chk #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_rdata  (cfg_rdata),
    .rx_wr_addr (rx_wr_addr),
    .rx_rd_addr (rx_rd_addr),
    .rx_level   (rx_level),
    .tx_level   (tx_level),
    .rx_trig    (rx_trig),
    .rx_irq     (rx_irq),
    .tx_irq     (tx_irq),
    .rx_overrun (rx_overrun),
    .tx_underrun(tx_underrun)
);

// File: tb/tb_uart_fifo_ctrl.sv
`timescale 1ns/1ps
module tb_uart_fifo_ctrl;

    localparam int DEPTH = 64;
    localparam int AW    = 6;
    localparam int LW    = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [7:0]    cfg_wdata = '0;
    logic          enh_en = 1'b0;
    logic          rx_push = 1'b0, rx_pop = 1'b0, tx_push = 1'b0, tx_pop = 1'b0;
    logic [7:0]    cfg_rdata;
    logic          dma_mode;
    logic [AW-1:0] rx_wr_addr, rx_rd_addr, tx_wr_addr, tx_rd_addr;
    logic [LW-1:0] rx_level, tx_level, rx_trig, tx_trig;
    logic          rx_irq, tx_irq, rx_overrun, rx_underrun, tx_overrun, tx_underrun;

    always #2.5 clk = ~clk;

    uart_fifo_ctrl #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .enh_en(enh_en), .rx_push(rx_push), .rx_pop(rx_pop),
        .tx_push(tx_push), .tx_pop(tx_pop), .cfg_rdata(cfg_rdata),
        .dma_mode(dma_mode), .rx_wr_addr(rx_wr_addr), .rx_rd_addr(rx_rd_addr),
        .tx_wr_addr(tx_wr_addr), .tx_rd_addr(tx_rd_addr), .rx_level(rx_level),
        .tx_level(tx_level), .rx_trig(rx_trig), .tx_trig(tx_trig),
        .rx_irq(rx_irq), .tx_irq(tx_irq), .rx_overrun(rx_overrun),
        .rx_underrun(rx_underrun), .tx_overrun(tx_overrun),
        .tx_underrun(tx_underrun)
    );

    int  n_vec = 0, n_bad = 0;
    bit  done = 1'b0;

    // Requirement-level model
    int  rcnt, tcnt, rwp, rrp, twp, trp, tst, code_m;
    bit  en_m, enh_m, enh_q_m, dma_m, pend_r, pend_t;
    bit  rovr, rudr, tovr, tudr;
    int  rfld, tfld;

    function automatic int rx_t(int c);
        case (c) 0: return 8; 1: return 16; 2: return 56; default: return 60; endcase
    endfunction

    function automatic int tx_t(int c, bit e);
        if (!e) return 1;
        case (c) 0: return 8; 1: return 16; 2: return 32; default: return 56; endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // R11 / R12 / R13 transmit request model: 0 request, 1 filled, 2 held
    task automatic tx_upd(input bit popped);
        int tg;
        tg = tx_t(code_m, enh_q_m);
        case (tst)
            0: if (tcnt != 0 && tcnt >= tg) tst = 1;
            1: if (tcnt == 0) tst = 0;
               else if (tcnt < tg) tst = popped ? 0 : 2;
            default: if (tcnt == 0) tst = 0;
                     else if (tcnt >= tg) tst = 1;
        endcase
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R3 rx_level"}, int'(rx_level), rcnt);
        chk({tag, " R3 tx_level"}, int'(tx_level), tcnt);
        chk({tag, " R3 rx_wr_addr"}, int'(rx_wr_addr), rwp);
        chk({tag, " R3 rx_rd_addr"}, int'(rx_rd_addr), rrp);
        chk({tag, " R3 tx_wr_addr"}, int'(tx_wr_addr), twp);
        chk({tag, " R3 tx_rd_addr"}, int'(tx_rd_addr), trp);
        chk({tag, " R4 rx_overrun"}, int'(rx_overrun), int'(rovr));
        chk({tag, " R4 rx_underrun"}, int'(rx_underrun), int'(rudr));
        chk({tag, " R4 tx_overrun"}, int'(tx_overrun), int'(tovr));
        chk({tag, " R4 tx_underrun"}, int'(tx_underrun), int'(tudr));
        chk({tag, " R7 rx_trig"}, int'(rx_trig), rx_t(code_m));
        chk({tag, " R8 tx_trig"}, int'(tx_trig), tx_t(code_m, enh_q_m));
        chk({tag, " R10 rx_irq"}, int'(rx_irq), int'(en_m && rcnt >= rx_t(code_m)));
        chk({tag, " R11 R12 R13 tx_irq"}, int'(tx_irq), int'(en_m && tst == 0));
        chk({tag, " R5 R6 R9 cfg_rdata"}, int'(cfg_rdata),
            rfld * 64 + tfld * 16 + int'(dma_m) * 8 + int'(pend_t) * 4 +
            int'(pend_r) * 2 + int'(en_m));
        chk({tag, " R6 dma_mode"}, int'(dma_mode), int'(dma_m));
    endtask

    task automatic step(input string tag, input bit rp, input bit rq,
                        input bit tp, input bit tq);
        bit fr, ft, rpa, rqa, tpa, tqa;
        rx_push = rp; rx_pop = rq; tx_push = tp; tx_pop = tq;
        @(posedge clk);
        @(negedge clk);
        rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0;
        fr = pend_r || !en_m;
        ft = pend_t || !en_m;
        rovr = !fr && rp && rcnt == DEPTH;
        rudr = !fr && rq && rcnt == 0;
        tovr = !ft && tp && tcnt == DEPTH;
        tudr = !ft && tq && tcnt == 0;
        rpa = !fr && rp && rcnt < DEPTH;
        rqa = !fr && rq && rcnt > 0;
        tpa = !ft && tp && tcnt < DEPTH;
        tqa = !ft && tq && tcnt > 0;
        if (fr) begin rcnt = 0; rwp = 0; rrp = 0; end
        else begin
            rcnt = rcnt + int'(rpa) - int'(rqa);
            rwp = (rwp + int'(rpa)) % DEPTH;
            rrp = (rrp + int'(rqa)) % DEPTH;
        end
        if (ft) begin tcnt = 0; twp = 0; trp = 0; end
        else begin
            tcnt = tcnt + int'(tpa) - int'(tqa);
            twp = (twp + int'(tpa)) % DEPTH;
            trp = (trp + int'(tqa)) % DEPTH;
        end
        pend_r = 0; pend_t = 0;
        enh_q_m = enh_en;
        tx_upd(tqa);
        check_all(tag);
    endtask

    task automatic cfg(input string tag, input logic [7:0] d);
        bit was_off;
        was_off = !en_m;
        cfg_wr = 1'b1; cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0;
        if (was_off || pend_r) begin rcnt = 0; rwp = 0; rrp = 0; end
        if (was_off || pend_t) begin tcnt = 0; twp = 0; trp = 0; end
        enh_m = enh_en;
        enh_q_m = enh_en;
        en_m = d[0];
        dma_m = d[3];
        rfld = int'(d[7:6]);
        if (enh_m) tfld = int'(d[5:4]);
        code_m = enh_m ? int'(d[5:4]) : int'(d[7:6]);
        pend_r = d[0] & d[1];
        pend_t = d[0] & d[2];
        rovr = 0; rudr = 0; tovr = 0; tudr = 0;
        tx_upd(1'b0);
        check_all(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rcnt = 0; tcnt = 0; rwp = 0; rrp = 0; twp = 0; trp = 0; tst = 0;
        code_m = 0; en_m = 0; enh_m = 0; enh_q_m = 0; dma_m = 0;
        pend_r = 0; pend_t = 0; rovr = 0; rudr = 0; tovr = 0; tudr = 0;
        rfld = 0; tfld = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_all("R1");

        // R2 strobes ignored while disabled
        step("R2", 1, 1, 1, 1);
        step("R2", 1, 0, 1, 0);
        step("R2", 0, 1, 0, 1);
        cfg("R2", 8'h01);
        for (int i = 0; i < 5; i++) step("R3", 1, 0, 1, 0);

        // R5 receive flush only
        cfg("R5", 8'h03);
        step("R5", 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) step("R3", 1, 0, 0, 0);
        // R5 transmit flush only
        cfg("R5", 8'h05);
        step("R5", 0, 0, 0, 0);
        // R5 flush bits without enable read back 0; queue disabled
        cfg("R5", 8'h06);
        step("R2", 1, 0, 1, 0);
        cfg("R2", 8'h01);

        // R6 block-transfer mode flag
        cfg("R6", 8'h09);
        cfg("R6", 8'h01);

        // R7 R8 R9 shared code and gated field
        enh_en = 1'b0;
        cfg("R9", 8'h31);
        enh_en = 1'b1;
        cfg("R7", 8'h31);
        cfg("R7", 8'h41);
        enh_en = 1'b0;
        cfg("R8", 8'h81);

        // R13 raised trigger under a filled queue
        enh_en = 1'b1;
        cfg("R13", 8'h01);
        for (int i = 0; i < 10; i++) step("R11", 0, 0, 1, 0);
        cfg("R13", 8'h31);
        for (int i = 0; i < 9; i++) step("R13", 0, 0, 0, 1);
        step("R12", 0, 0, 0, 1);
        for (int i = 0; i < 3; i++) step("R11", 0, 0, 1, 0);

        // Sweep every code with enhanced mode off and on
        for (int e = 0; e < 2; e++) begin
            for (int s = 0; s < 4; s++) begin
                enh_en = e[0];
                cfg("R7", {s[1:0], s[1:0], 4'b0111});
                step("R5", 0, 0, 0, 0);
                for (int i = 0; i < DEPTH; i++) step("R10", 1, 0, 1, 0);
                step("R4", 1, 0, 1, 0);
                step("R4", 1, 1, 1, 1);
                step("R3", 1, 1, 1, 1);
                for (int i = 0; i < DEPTH - 1; i++) step("R11", 0, 1, 0, 1);
                step("R4", 0, 1, 0, 1);
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule